// File: doc/BRIEF.md
# Zero-Voltage-Switching Full-Bridge Gate Steering Controller

This block produces the four gate commands of a full-bridge power stage from a clock-driven digital oscillator. Every oscillator period has an on-window, in which a digital ramp climbs, followed by a deadtime. Two consecutive periods form one switching cycle. The two upper switches run at a fixed half-cycle duty, in opposition. The two lower switches alternate between the halves and carry all of the pulse-width modulation. Each lower pulse ends on its trailing edge, when the ramp reaches the duty command.

The upper pair changes state inside the deadtime. The change comes a programmable fraction of the deadtime before the next lower switch turns on. This gives the bridge node time to ring down to zero volts before the lower switch closes. An asynchronous terminate request, normally from a peak-current comparator, cuts the active lower pulse short. Steering logic keeps the lower pulses strictly alternating when small duties cause half-cycles to be skipped.

Top module: `zvs_bridge_steer`

## Requirements
- R1: An oscillator period lasts `chg_len + dead_len` clock cycles: an on-window of `chg_len` cycles, then a deadtime of `dead_len` cycles. A setting of 0 is treated as 1.
- R2: A switching cycle is two periods. Half-cycle 0 (even periods) comes first after start-up, then half-cycle 1 (odd periods).
- R3: `gate_ul` and `gate_ur` are never high together while running. Each is high for one period per switching cycle. They change state only inside a deadtime, or on the first on-window cycle when the delay is zero.
- R4: A lower pulse starts on the first on-window cycle of its half-cycle. It lasts `min(duty, chg_len)` cycles, so it ends when the ramp count reaches `duty` or when the on-window ends.
- R5: The upper pair reaches its new state `rd` cycles before the deadtime ends, with `rd = floor(rdel * dead_len / (2^RD_W - 1))`. Code 0 gives 0 cycles. Full-scale code gives the whole deadtime.
- R6: Pairing: half-cycle 0 drives `gate_lr` with `gate_ul` high. Half-cycle 1 drives `gate_ll` with `gate_ur` high.
- R7: Two consecutive lower pulses never go to the same output. A half-cycle whose output matches the previous pulse's output is suppressed.
- R8: `term_req` passes through a two-flop synchronizer. The lower output is low from the cycle after the second flop captures it. No further pulse appears in that half-cycle, because the ramp is cleared.
- R9: A `duty` at or below `ZERO_TH` (default 2) gives no lower pulse in that half-cycle. The upper outputs keep alternating.
- R10: `dis` high at a clock edge drives all four outputs low from that edge on. Releasing it restarts at half-cycle 0, as after reset.
- R11: `chg_len`, `dead_len` and `rdel` are captured only at the start of a switching cycle. `duty` acts directly.
- R12: During reset all outputs are low. The first edge after release starts the on-window of half-cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dis | input | 1 | Synchronous disable, active high |
| chg_len | input | CNT_W | On-window length in cycles |
| dead_len | input | CNT_W | Deadtime length in cycles |
| duty | input | CNT_W | Duty command, compared with the ramp count |
| rdel | input | RD_W | Resonant-delay code, a fraction of the deadtime |
| term_req | input | 1 | Asynchronous pulse-terminate request |
| gate_ul | output | 1 | Upper-left gate command |
| gate_ur | output | 1 | Upper-right gate command |
| gate_ll | output | 1 | Lower-left gate command |
| gate_lr | output | 1 | Lower-right gate command |

## Verification
The bench drives the delay code at 0 and full scale. An off-by-one in the delay arithmetic would move the upper swap into the on-window, or past the lower turn-on. It zeroes the duty for exactly one half-cycle. A design without suppression would then give the same lower switch two pulses in a row. It also asserts a terminate request in mid-pulse, and a careless ramp clear would restart the pulse in the same half-cycle. Finally, it changes the deadtime in the middle of a switching cycle. A design that takes new settings at once would shift the next half-cycle boundary, and the upper pair would lose its equal high times.

// File: rtl/zvs_pkg.sv
package zvs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CHG, PH_DEAD} phase_t;
endpackage

// File: rtl/zvs_timebase.sv
module zvs_timebase
  import zvs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RD_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis,
  input  logic [CNT_W-1:0] chg_in,
  input  logic [CNT_W-1:0] dead_in,
  input  logic [RD_W-1:0]  rdel_in,
  output logic             run,
  output logic             in_chg,
  output logic             side,
  output logic             chg_last,
  output logic             to_chg,
  output logic             nxt_side,
  output logic             up_flip
);
  localparam int FS = (1 << RD_W) - 1;
  localparam int PW = CNT_W + RD_W;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // delay cycles = code * deadtime / full scale, truncated
  function automatic logic [CNT_W-1:0] rd_cycles(input logic [RD_W-1:0] code,
                                                 input logic [CNT_W-1:0] dl);
    logic [PW-1:0] prod;
    prod = PW'(code) * PW'(dl);
    prod = prod / PW'(FS);
    return prod[CNT_W-1:0];
  endfunction

  phase_t           ph;
  logic [CNT_W-1:0] cnt, chg_q, dead_q, rdc;
  logic             dead_last, load_now;
  logic [CNT_W:0]   dsum;

  assign chg_last  = (ph == PH_CHG)  && (cnt == chg_q - 1'b1);
  assign dead_last = (ph == PH_DEAD) && (cnt == dead_q - 1'b1);
  assign load_now  = (ph == PH_IDLE) || (dead_last && side);
  assign to_chg    = (ph == PH_IDLE) || dead_last;
  assign nxt_side  = (ph == PH_IDLE) ? 1'b0 : ~side;
  assign run       = (ph != PH_IDLE);
  assign in_chg    = (ph == PH_CHG);
  assign dsum      = {1'b0, cnt} + {1'b0, rdc} + (CNT_W+1)'(1);
  // upper pair reaches its new state rdc cycles before the deadtime ends
  assign up_flip   = ((ph == PH_DEAD) && (dsum == {1'b0, dead_q})) ||
                     (chg_last && (rdc == dead_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; side <= 1'b0;
      chg_q <= CNT_W'(1); dead_q <= CNT_W'(1); rdc <= '0;
    end else if (dis) begin
      ph <= PH_IDLE; cnt <= '0; side <= 1'b0;
      chg_q <= CNT_W'(1); dead_q <= CNT_W'(1); rdc <= '0;
    end else begin
      if (load_now) begin
        chg_q  <= at_least_one(chg_in);
        dead_q <= at_least_one(dead_in);
        rdc    <= rd_cycles(rdel_in, at_least_one(dead_in));
      end
      unique case (ph)
        PH_IDLE: begin ph <= PH_CHG; cnt <= '0; side <= 1'b0; end
        PH_CHG:  if (chg_last) begin ph <= PH_DEAD; cnt <= '0; end
                 else cnt <= cnt + 1'b1;
        PH_DEAD: if (dead_last) begin ph <= PH_CHG; cnt <= '0; side <= ~side; end
                 else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_chg_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_CHG) |-> (cnt < chg_q));
  p_dead_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DEAD) |-> (cnt < dead_q));
  p_rd_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rdc <= dead_q));
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || dis)
    (run && !load_now) |=> ($stable(dead_q) && $stable(chg_q) && $stable(rdc)));
endmodule

// File: rtl/zvs_upper.sv
module zvs_upper (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic run,
  input  logic up_flip,
  output logic up_l,
  output logic up_r
);
  logic up_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       up_sel <= 1'b0;
    else if (dis)     up_sel <= 1'b0;
    else if (up_flip) up_sel <= ~up_sel;
  end

  assign up_l = run & ~up_sel;
  assign up_r = run & up_sel;

  p_up_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_l && up_r));
endmodule

// File: rtl/zvs_lower_steer.sv
module zvs_lower_steer #(
  parameter int CNT_W   = 8,
  parameter int ZERO_TH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis,
  input  logic             in_chg,
  input  logic             side,
  input  logic             chg_last,
  input  logic             to_chg,
  input  logic             nxt_side,
  input  logic [CNT_W-1:0] duty,
  input  logic             term_s,
  output logic             lo_l,
  output logic             lo_r
);
  logic             live, last_r, lo_on;
  logic [CNT_W-1:0] ramp;

  // half-cycle 0 steers to the right output, half-cycle 1 to the left
  assign lo_on = in_chg && live && !term_s && (ramp < duty);
  assign lo_r  = lo_on & ~side;
  assign lo_l  = lo_on & side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0; ramp <= '0; last_r <= 1'b0;
    end else if (dis) begin
      live <= 1'b0; ramp <= '0; last_r <= 1'b0;
    end else begin
      if (to_chg) begin
        live <= (duty > CNT_W'(ZERO_TH)) && (last_r == nxt_side);
        ramp <= '0;
      end else if (lo_on && !chg_last) begin
        ramp <= ramp + 1'b1;
      end else begin
        live <= 1'b0;
        ramp <= '0;
      end
      if (lo_on) last_r <= ~side;
    end
  end

  p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n || dis)
    (lo_on && !$past(lo_on)) |-> (last_r == side));
  p_term_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || dis)
    (term_s && !to_chg) |=> !lo_on);
endmodule

// File: rtl/zvs_bridge_steer.sv
module zvs_bridge_steer #(
  parameter int CNT_W   = 8,
  parameter int RD_W    = 4,
  parameter int ZERO_TH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis,
  input  logic [CNT_W-1:0] chg_len,
  input  logic [CNT_W-1:0] dead_len,
  input  logic [CNT_W-1:0] duty,
  input  logic [RD_W-1:0]  rdel,
  input  logic             term_req,
  output logic             gate_ul,
  output logic             gate_ur,
  output logic             gate_ll,
  output logic             gate_lr
);
  logic run, in_chg, side, chg_last, to_chg, nxt_side, up_flip;
  logic term_m, term_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin term_m <= 1'b0; term_s <= 1'b0; end
    else        begin term_m <= term_req; term_s <= term_m; end
  end

  zvs_timebase #(.CNT_W(CNT_W), .RD_W(RD_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .dis(dis),
    .chg_in(chg_len), .dead_in(dead_len), .rdel_in(rdel),
    .run(run), .in_chg(in_chg), .side(side), .chg_last(chg_last),
    .to_chg(to_chg), .nxt_side(nxt_side), .up_flip(up_flip));

  zvs_upper u_up (
    .clk(clk), .rst_n(rst_n), .dis(dis), .run(run), .up_flip(up_flip),
    .up_l(gate_ul), .up_r(gate_ur));

  zvs_lower_steer #(.CNT_W(CNT_W), .ZERO_TH(ZERO_TH)) u_lo (
    .clk(clk), .rst_n(rst_n), .dis(dis), .in_chg(in_chg), .side(side),
    .chg_last(chg_last), .to_chg(to_chg), .nxt_side(nxt_side),
    .duty(duty), .term_s(term_s), .lo_l(gate_ll), .lo_r(gate_lr));

  p_pair_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lr |-> gate_ul);
  p_pair_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ll |-> gate_ur);
  p_dis_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !(gate_ul || gate_ur || gate_ll || gate_lr));
endmodule

// File: tb/test_zvs_bridge_steer.sv
module test_zvs_bridge_steer;
  localparam int ZT = 2;
  localparam int FS = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, dis, term_req;
  logic [7:0] chg_len, dead_len, duty;
  logic [3:0] rdel;
  logic       gate_ul, gate_ur, gate_ll, gate_lr;

  int n_chk = 0, n_err = 0, u_now = 0;

  zvs_bridge_steer i_zvs_bridge_steer (
    .clk(clk), .rst_n(rst_n), .dis(dis), .chg_len(chg_len), .dead_len(dead_len),
    .duty(duty), .rdel(rdel), .term_req(term_req),
    .gate_ul(gate_ul), .gate_ur(gate_ur), .gate_ll(gate_ll), .gate_lr(gate_lr));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (u=%0d)", tag, act, exp, u_now);
    end
  endtask

  // largest r with r*FS <= code*d
  function automatic int rd_of(int code, int d);
    int r = 0;
    while ((r + 1) * FS <= code * d) r++;
    return r;
  endfunction

  // expected {ul, ur, ll, lr} in cycle u after start, steady settings, no skips
  function automatic logic [3:0] model(int u, int c, int d, int code, int dt);
    int p, h, pos, w, flips;
    logic ul, on;
    p = c + d;
    flips = (u + rd_of(code, d)) / p;
    ul = (flips % 2) == 0;
    h = u / p;
    pos = u % p;
    w = (dt > ZT) ? ((dt < c) ? dt : c) : 0;
    on = pos < w;
    return {ul, !ul, on && (h % 2 == 1), on && (h % 2 == 0)};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    u_now++;
  endtask

  task automatic restart(int c, int d, int code, int dt);
    @(negedge clk);
    dis = 1'b1;
    chg_len = 8'(c); dead_len = 8'(d); rdel = 4'(code); duty = 8'(dt);
    @(posedge clk);
    @(negedge clk);
    #1 dis = 1'b0;
    u_now = -1;
  endtask

  task automatic run_cfg(int c, int d, int code, int dt, int halves);
    logic [3:0] m;
    restart(c, d, code, dt);
    for (int k = 0; k < halves * (c + d); k++) begin
      tick();
      m = model(u_now, c, d, code, dt);
      chk("R2/R3/R5 upper pair", {gate_ul, gate_ur}, m[3:2]);
      chk("R1/R4/R6/R9 lower pair", {gate_ll, gate_lr}, m[1:0]);
    end
  endtask

  // R7 monitor: consecutive lower pulses must change output
  logic prev_ll = 1'b0, prev_lr = 1'b0;
  int   last_out = 0;   // 0 left, 1 right
  always @(negedge clk) begin
    if (rst_n && !dis) begin
      if (gate_lr && !prev_lr) begin
        n_chk++;
        if (last_out == 1) begin
          n_err++;
          $display("FAIL R7 alternation: actual=right expected=left");
        end
        last_out = 1;
      end
      if (gate_ll && !prev_ll) begin
        n_chk++;
        if (last_out == 0) begin
          n_err++;
          $display("FAIL R7 alternation: actual=left expected=right");
        end
        last_out = 0;
      end
      prev_ll = gate_ll; prev_lr = gate_lr;
    end else begin
      last_out = 0; prev_ll = 1'b0; prev_lr = 1'b0;
    end
  end

  initial begin
    #(8 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; dis = 1'b0; term_req = 1'b0;
    chg_len = 8'd6; dead_len = 8'd3; duty = 8'd5; rdel = 4'd8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset outputs", {gate_ul, gate_ur, gate_ll, gate_lr}, 0);
    rst_n = 1'b1;
    u_now = -1;
    tick();
    chk("R12 first cycle upper-left", gate_ul, 1);
    chk("R12 first cycle lower-right", gate_lr, 1);

    // delay code extremes
    run_cfg(5, 6, 0, 4, 6);
    run_cfg(5, 6, 15, 4, 6);
    run_cfg(3, 1, 15, 9, 6);
    // zero threshold boundary
    run_cfg(6, 3, 7, 2, 4);
    run_cfg(6, 3, 7, 3, 4);
    // duty beyond the on-window
    run_cfg(5, 2, 5, 20, 4);

    // R7: one skipped half-cycle suppresses the next same-side pulse
    restart(6, 3, 5, 4);
    while (u_now < 8) tick();
    duty = 8'd0;
    while (u_now < 9 + 6) tick();
    duty = 8'd4;
    while (u_now < 18) tick();
    chk("R7 suppressed same-side pulse", gate_lr, 0);
    while (u_now < 27) tick();
    chk("R7 pulse resumes on opposite side", gate_ll, 1);

    // R8: terminate in mid-pulse
    restart(10, 3, 5, 9);
    while (u_now < 1) tick();
    term_req = 1'b1;
    tick();
    chk("R8 still on before sync", gate_lr, 1);
    tick();
    chk("R8 pulse cut", gate_lr, 0);
    term_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R8 no restart in half", gate_lr, 0);
    end
    while (u_now < 13) tick();
    chk("R8 next half pulses", gate_ll, 1);

    // R10: disable in mid-run
    restart(6, 4, 6, 5);
    while (u_now < 12) tick();
    dis = 1'b1;
    tick();
    chk("R10 all low after disable", {gate_ul, gate_ur, gate_ll, gate_lr}, 0);
    tick();
    chk("R10 stays low", {gate_ul, gate_ur, gate_ll, gate_lr}, 0);

    // R11: settings changed within a switching cycle take effect next cycle
    restart(4, 4, 0, 3);
    while (u_now < 9) tick();
    dead_len = 8'd8;
    while (u_now < 15) tick();
    chk("R11 old deadtime kept", gate_lr, 0);
    chk("R11 old deadtime upper", gate_ul, 0);
    tick();
    chk("R11 boundary at old period", gate_lr, 1);
    chk("R11 upper at old period", gate_ul, 1);
    while (u_now < 27) tick();
    chk("R11 new deadtime in use", gate_ll, 0);
    tick();
    chk("R11 boundary at new period", gate_ll, 1);

    // constrained random configurations
    for (int n = 0; n < 25; n++) begin
      int c, d, code, dt;
      c = 2 + int'($urandom % 11);
      d = 1 + int'($urandom % 10);
      code = int'($urandom % 16);
      dt = int'($urandom % 15);
      run_cfg(c, d, code, dt, 6);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule